// File: doc/BRIEF.md
# Hierarchical Nibble-Split Column Multiplier

This block multiplies two unsigned 8-bit operands and returns the 16-bit product. It divides each operand into an upper and a lower nibble and forms the four nibble-by-nibble partial products in four identical 4x4 cores. Each core works column by column, vertically and crosswise. Column k adds up every bit product whose two bit indices sum to k, and it also adds the carry left over from column k-1. The column sum is formed in a small ripple adder built from full-adder cells.

The four partial products are shifted into place and summed by a chain of three 16-bit ripple adders. A parameter selects one of two output forms. In the registered form, the product and a valid flag appear one clock after the operands are sampled. In the combinational form, the product and the valid flag follow the inputs in the same cycle.

Top module: `vcm_mul8`

## Requirements
- R1: `prod` equals the unsigned arithmetic product `op_x * op_y` for every pair of 8-bit operands.
- R2: The 4x4 core returns the 8-bit unsigned product for all 256 input pairs. For example, 4'b1001 times 4'b1010 gives 8'b01011010 (90).
- R3: In the 4x4 core, output bit k (for k from 0 to 6) is the low bit of column k's sum. That sum is the count of bit products a[i]&b[j] with i+j=k plus the carry from column k-1. The carry left after column 6 is at most 1 and forms bit 7.
- R4: The low nibble of X times the low nibble of Y lands unshifted. The high nibble of X times the low nibble of Y, and the low nibble of X times the high nibble of Y, both land shifted left by 4. The product of the two high nibbles lands shifted left by 8.
- R5: The partial products are summed with three 16-bit adders, and none of them ever produces a carry out of bit 15.
- R6: The full-adder cell gives sum = a^b^ci and carry = a&b | ci&(a^b) for all eight input combinations.
- R7: Corner products hold: 0 times anything is 0, 1 times X is X, 0xFF times 0xFF is 0xFE01, 0x80 times 0x80 is 0x4000, and 17 times 4 is 68.
- R8: With `REG_OUT=1`, `prod` and `out_valid` show the product and the `in_valid` value sampled at the previous rising clock edge.
- R9: With `REG_OUT=1`, a clock edge with `rst` high clears `prod` to 0 and `out_valid` to 0. This holds even when `in_valid` is high at that edge.
- R10: With `REG_OUT=0`, `prod` is the product of the current operands and `out_valid` equals `in_valid` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands valid this cycle |
| op_x | input | 8 | Unsigned multiplicand |
| op_y | input | 8 | Unsigned multiplier |
| prod | output | 16 | Unsigned product |
| out_valid | output | 1 | Product valid |

## Verification
Two events can share one clock edge in the registered form. First, a new operand pair can be captured on the same edge that presents the previous result; the bench streams a new random pair every cycle and compares each output against the pair driven one cycle earlier. Second, reset can arrive while `in_valid` is high; the bench drives both high together and requires a zero product and a low valid flag after that edge.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  localparam int unsigned VCM_NIB = 4;

  // width of a column accumulator in an n x n core:
  // holds up to n bit products plus the incoming carry
  function automatic int unsigned col_width(input int unsigned n);
    return $clog2(n) + 2;
  endfunction
endpackage

// File: rtl/vcm_fa_cell.sv
module vcm_fa_cell (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  logic hx;
  assign hx = a ^ b;
  assign s  = hx ^ ci;
  assign co = (a & b) | (ci & hx);
endmodule

// File: rtl/vcm_rca.sv
module vcm_rca #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] cy;
  assign cy[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    vcm_fa_cell u_fa (
      .a (a[i]),
      .b (b[i]),
      .ci(cy[i]),
      .s (sum[i]),
      .co(cy[i+1])
    );
  end

  assign cout = cy[W];
endmodule

// File: rtl/vcm_core4.sv
module vcm_core4
  import vcm_pkg::*;
#(
  parameter int unsigned N = VCM_NIB
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  localparam int unsigned COLS = 2*N - 1;
  localparam int unsigned CW   = col_width(N);

  logic [CW-1:0]   carry [COLS+1];
  logic [COLS-1:0] col_ovf;

  assign carry[0] = '0;

  for (genvar k = 0; k < COLS; k++) begin : g_col
    logic [N-1:0]  diag;
    logic [CW-1:0] cnt;
    logic [CW-1:0] csum;

    // crosswise bit products of this column
    for (genvar i = 0; i < N; i++) begin : g_term
      if ((k - i >= 0) && (k - i < N)) begin : g_on
        assign diag[i] = a[i] & b[k-i];
      end else begin : g_off
        assign diag[i] = 1'b0;
      end
    end

    assign cnt = CW'($countones(diag));

    vcm_rca #(.W(CW)) u_colsum (
      .a   (cnt),
      .b   (carry[k]),
      .cin (1'b0),
      .sum (csum),
      .cout(col_ovf[k])
    );

    assign p[k]       = csum[0];
    assign carry[k+1] = {1'b0, csum[CW-1:1]};
  end

  assign p[2*N-1] = carry[COLS][0];

  // R3: final carry fits in one bit, no column accumulator wraps
  always_comb begin
    if (!$isunknown({a, b})) begin
      p_last_carry_r3: assert (carry[COLS][CW-1:1] == '0);
      p_col_wrap_r3:   assert (col_ovf == '0);
    end
  end
endmodule

// File: rtl/vcm_mul8.sv
module vcm_mul8
  import vcm_pkg::*;
#(
  parameter int unsigned XW      = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [XW-1:0]   op_x,
  input  logic [XW-1:0]   op_y,
  output logic [2*XW-1:0] prod,
  output logic            out_valid
);
  localparam int unsigned HW = XW / 2;
  localparam int unsigned PW = 2 * XW;

  logic [HW-1:0] x_hi, x_lo, y_hi, y_lo;
  assign x_hi = op_x[XW-1:HW];
  assign x_lo = op_x[HW-1:0];
  assign y_hi = op_y[XW-1:HW];
  assign y_lo = op_y[HW-1:0];

  logic [2*HW-1:0] pp_ll, pp_hl, pp_lh, pp_hh;

  vcm_core4 #(.N(HW)) u_ll (.a(x_lo), .b(y_lo), .p(pp_ll));
  vcm_core4 #(.N(HW)) u_hl (.a(x_hi), .b(y_lo), .p(pp_hl));
  vcm_core4 #(.N(HW)) u_lh (.a(x_lo), .b(y_hi), .p(pp_lh));
  vcm_core4 #(.N(HW)) u_hh (.a(x_hi), .b(y_hi), .p(pp_hh));

  // aligned partial products
  logic [PW-1:0] al_ll, al_hl, al_lh, al_hh;
  assign al_ll = {{(PW-2*HW){1'b0}}, pp_ll};
  assign al_hl = {{(PW-3*HW){1'b0}}, pp_hl, {HW{1'b0}}};
  assign al_lh = {{(PW-3*HW){1'b0}}, pp_lh, {HW{1'b0}}};
  assign al_hh = {pp_hh, {(2*HW){1'b0}}};

  logic [PW-1:0] s1, s2, s3;
  logic          c1, c2, c3;

  vcm_rca #(.W(PW)) u_add1 (.a(al_ll), .b(al_hl), .cin(1'b0), .sum(s1), .cout(c1));
  vcm_rca #(.W(PW)) u_add2 (.a(s1),    .b(al_lh), .cin(1'b0), .sum(s2), .cout(c2));
  vcm_rca #(.W(PW)) u_add3 (.a(s2),    .b(al_hh), .cin(1'b0), .sum(s3), .cout(c3));

  always_comb begin
    if (!$isunknown({op_x, op_y})) begin
      p_no_overflow_r5: assert ({c1, c2, c3} == 3'b000);
      p_align_lsb_r4:   assert (s3[HW-1:0] == pp_ll[HW-1:0]);
    end
  end

  if (REG_OUT) begin : g_reg
    logic [PW-1:0] prod_q;
    logic          vld_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        prod_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        prod_q <= s3;
        vld_q  <= in_valid;
      end
    end

    assign prod      = prod_q;
    assign out_valid = vld_q;

    p_valid_lat_r8: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (out_valid == $past(in_valid)));

    p_prod_lat_r1: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && out_valid) |-> (prod == PW'($past(op_x)) * PW'($past(op_y))));

    p_reset_clear_r9: assert property (@(posedge clk)
      rst |=> (!out_valid && prod == '0));
  end else begin : g_comb
    assign prod      = s3;
    assign out_valid = in_valid;
  end
endmodule

// File: tb/vcm_mul8_test.sv
`timescale 1ns/1ps
module vcm_mul8_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  op_x = '0, op_y = '0;
  logic [15:0] prod, prod_c;
  logic        out_valid, out_valid_c;
  logic [3:0]  ca = '0, cb = '0;
  logic [7:0]  cp;
  logic        fa_a = 1'b0, fa_b = 1'b0, fa_ci = 1'b0, fa_s, fa_co;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  vcm_mul8 #(.XW(8), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_x(op_x), .op_y(op_y),
    .prod(prod), .out_valid(out_valid));

  vcm_mul8 #(.XW(8), .REG_OUT(1'b0)) uut_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_x(op_x), .op_y(op_y),
    .prod(prod_c), .out_valid(out_valid_c));

  vcm_core4 #(.N(4)) u_core (.a(ca), .b(cb), .p(cp));

  vcm_fa_cell u_cell (.a(fa_a), .b(fa_b), .ci(fa_ci), .s(fa_s), .co(fa_co));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at negedge, result visible at the following negedge
  task automatic run_reg(input string req, input logic [7:0] x, input logic [7:0] y);
    @(negedge clk);
    op_x = x; op_y = y; in_valid = 1'b1;
    #0.5;
    chk({req, " R10 comb"}, prod_c, 16'(x) * 16'(y));
    @(negedge clk);
    chk({req, " R8 valid"}, {15'b0, out_valid}, 16'd1);
    chk(req, prod, 16'(x) * 16'(y));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R9 reset prod", prod, 16'd0);
    chk("R9 reset valid", {15'b0, out_valid}, 16'd0);
  endtask

  task automatic t_cell;
    for (int v = 0; v < 8; v++) begin
      fa_a = v[0]; fa_b = v[1]; fa_ci = v[2];
      #1;
      chk("R6 cell sum", {15'b0, fa_s}, {15'b0, v[0] ^ v[1] ^ v[2]});
      chk("R6 cell carry", {15'b0, fa_co},
          {15'b0, (v[0] & v[1]) | (v[2] & (v[0] ^ v[1]))});
    end
  endtask

  task automatic t_core;
    ca = 4'b1001; cb = 4'b1010;
    #1;
    chk("R2 core 9x10", {8'b0, cp}, 16'h005A);
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        ca = 4'(i); cb = 4'(j);
        #1;
        chk("R2 R3 core", {8'b0, cp}, 16'(i * j));
      end
    end
  endtask

  task automatic t_corners;
    run_reg("R7 zero", 8'h00, 8'hA7);
    run_reg("R7 zero", 8'hFF, 8'h00);
    run_reg("R7 one", 8'h01, 8'hC3);
    run_reg("R7 max", 8'hFF, 8'hFF);
    run_reg("R7 msb", 8'h80, 8'h80);
    run_reg("R7 17x4", 8'b0001_0001, 8'b0000_0100);
  endtask

  task automatic t_align;
    run_reg("R4 lo-lo", 8'h0F, 8'h0D);
    run_reg("R4 hi-lo", 8'hB0, 8'h07);
    run_reg("R4 lo-hi", 8'h06, 8'hE0);
    run_reg("R4 hi-hi", 8'hF0, 8'h90);
  endtask

  // new pair every cycle: capture and present on the same edge
  task automatic t_stream;
    logic [7:0] px, py;
    @(negedge clk);
    px = 8'($urandom); py = 8'($urandom);
    op_x = px; op_y = py; in_valid = 1'b1;
    for (int n = 0; n < 10000; n++) begin
      @(negedge clk);
      chk("R1 R5 stream", prod, 16'(px) * 16'(py));
      chk("R8 stream valid", {15'b0, out_valid}, 16'd1);
      px = 8'($urandom); py = 8'($urandom);
      op_x = px; op_y = py; in_valid = (n % 7) != 3;
      #0.5;
      chk("R1 R10 comb", prod_c, 16'(px) * 16'(py));
      chk("R10 comb valid", {15'b0, out_valid_c}, {15'b0, in_valid});
      if (!in_valid) begin
        @(negedge clk);
        chk("R8 idle valid", {15'b0, out_valid}, 16'd0);
        chk("R1 idle prod", prod, 16'(px) * 16'(py));
        in_valid = 1'b1;
      end
    end
  endtask

  task automatic t_reset_collide;
    @(negedge clk);
    op_x = 8'hE7; op_y = 8'h3B; in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    chk("R9 reset wins prod", prod, 16'd0);
    chk("R9 reset wins valid", {15'b0, out_valid}, 16'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 after reset", {15'b0, out_valid}, 16'd1);
    chk("R1 after reset", prod, 16'hE7 * 16'h3B);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_cell();
    t_core();
    @(negedge clk);
    rst = 1'b0;
    t_corners();
    t_align();
    t_stream();
    t_reset_collide();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #900000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule